// File: doc/BRIEF.md
# Video DRAM Access Cycle Decoder

This block sits behind the strobe pins of a multiport video DRAM. It is clocked by a system clock and treats the active-low row strobe, the two byte column strobes, the transfer gate, the write enable and the special-function pin as synchronous levels. It finds the row-strobe falling edge and the first column-strobe falling edge by comparing each sample with the previous one. From the levels seen at those two points it classifies each access. An access is one of: a refresh variant, a full or split register transfer, a plain or masked write, a plain or masked block write, a write-mask register load, or a colour register load.

Each classified access produces a one-clock pulse on one bit of a one-hot operation vector, together with the latched row and column fields. The block also holds two sticky mode flags: persistent write-per-bit and stop-point, plus the 4-bit stop-point code. Other logic consumes these. An undefined combination raises a one-clock error pulse instead of an operation.

A three-state machine tracks the access:
- S_IDLE waits for the row fall. With the column strobe low it decodes a refresh and moves to S_WAIT_RAS_HIGH. Otherwise it stores the row-time levels and moves to S_ROW_OPEN.
- S_ROW_OPEN waits for the column fall. It decodes the access and moves to S_WAIT_RAS_HIGH, or to S_IDLE when the row strobe rises in the same sample. A row rise with no column fall returns it to S_IDLE silently.
- S_WAIT_RAS_HIGH returns to S_IDLE on the row rise.

Top module: `vdc_cycle_decoder`

## Requirements
- R1: The logical column strobe counts as low when casl_n or casu_n or both are low; either byte strobe alone is enough to make a refresh or to complete a column stage.
- R2: With the column strobe low at the row fall, {we_n,dsf} = 01 gives the stop-point-set refresh, 10 the option-reset refresh and 11 the no-reset refresh. The pulse appears on the clock edge that first samples the row strobe low, and row_addr holds the address sampled then.
- R3: With the column strobe low at the row fall, {we_n,dsf} = 00 is reserved. It pulses op_reserved for one clock with op_strobe all zero, and leaves both mode flags and stop_code unchanged.
- R4: With the column strobe high and trg_n low at the row fall, dsf low at the row fall gives a full transfer and dsf high gives a split transfer. The tap point is captured into col_addr at the column fall.
- R5: With the column strobe high, trg_n high and we_n low at the row fall, dsf at the column fall gives a masked write (low) or a masked block write (high).
- R6: With the column strobe high, trg_n high, we_n high and dsf high at the row fall, dsf at the column fall gives a write-mask load (low) or a colour load (high).
- R7: With trg_n, we_n high and dsf low at the row fall, dsf at the column fall gives a plain write (low) or a plain block write (high). blk_addr equals col_addr shifted right by log2(BLOCK_COLS), which is bits 8:2 by default.
- R8: A write-mask load sets pwpb_mode one clock after its pulse. Only the option-reset refresh clears it.
- R9: The stop-point-set refresh sets stop_mode and loads stop_code from addr[7:4] of the row-fall address; addr[3:0] and addr[8] have no effect.
- R10: The option-reset refresh clears pwpb_mode and stop_mode. The no-reset refresh leaves both unchanged.
- R11: A column fall sampled together with a row rise still completes the access, and the next access decodes normally. A row strobe cycle with no column fall produces no pulse.
- R12: op_strobe has at most one bit set, for one clock per access. The bit positions are: 0 stop-point-set refresh, 1 option-reset refresh, 2 no-reset refresh, 3 full transfer, 4 split transfer, 5 write, 6 masked write, 7 block write, 8 masked block write, 9 write-mask load, 10 colour load. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Lower byte column strobe, active low |
| casu_n | input | 1 | Upper byte column strobe, active low |
| trg_n | input | 1 | Transfer gate, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| addr | input | ADDR_W | Multiplexed address |
| op_strobe | output | 11 | One-hot operation pulse |
| op_reserved | output | 1 | Reserved-combination pulse |
| row_addr | output | ADDR_W | Address sampled at the row fall |
| col_addr | output | ADDR_W | Column, block or tap field sampled at the column fall |
| blk_addr | output | ADDR_W-log2(BLOCK_COLS) | Block address derived from col_addr |
| pwpb_mode | output | 1 | Persistent write-per-bit flag |
| stop_mode | output | 1 | Stop-point mode flag |
| stop_code | output | 4 | Latched stop-point code |

## Verification
The column-strobe fall and the row-strobe rise can land in the same sample. When they do, the access must still complete, and the machine must go straight to S_IDLE instead of waiting for a rise that has already happened. The bench provokes this by releasing the row strobe in the same sample in which it drops the column strobe. It expects a write pulse carrying the column address sampled then. It then runs a normal access right away and requires that access to decode correctly. A row strobe cycle with no column fall follows, and any pulse it produces is counted as an error by the scoreboard.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

    localparam int VDC_NUM_OPS = 11;

    // bit position of each operation inside the one-hot strobe vector
    typedef enum logic [3:0] {
        OP_REF_STOPSET  = 4'd0,
        OP_REF_OPTRST   = 4'd1,
        OP_REF_NORST    = 4'd2,
        OP_XFER_FULL    = 4'd3,
        OP_XFER_SPLIT   = 4'd4,
        OP_WRITE        = 4'd5,
        OP_WRITE_MASKED = 4'd6,
        OP_BLOCK        = 4'd7,
        OP_BLOCK_MASKED = 4'd8,
        OP_LOAD_WMASK   = 4'd9,
        OP_LOAD_COLOR   = 4'd10
    } vdc_op_e;

    typedef enum logic [1:0] {
        S_IDLE          = 2'd0,
        S_ROW_OPEN      = 2'd1,
        S_WAIT_RAS_HIGH = 2'd2
    } vdc_state_e;

    // control levels captured at the row-strobe fall
    typedef struct packed {
        logic trg_n;
        logic we_n;
        logic dsf;
    } vdc_row_sample_t;

endpackage

// File: rtl/vdc_strobe_sampler.sv
module vdc_strobe_sampler #(
    parameter int   N          = 2,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] prev
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic held;
        always_ff @(posedge clk) begin
            if (!rst_n) held <= IDLE_LEVEL;
            else        held <= sig[i];
        end
        assign prev[i] = held;
    end

endmodule

// File: rtl/vdc_cycle_fsm.sv
module vdc_cycle_fsm
    import vdc_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ras_n,
    input  logic                   ras_q,
    input  logic                   cas_n,
    input  logic                   cas_q,
    input  logic                   trg_n,
    input  logic                   we_n,
    input  logic                   dsf,
    input  logic [ADDR_W-1:0]      addr,
    output logic [VDC_NUM_OPS-1:0] op_strobe,
    output logic                   op_reserved,
    output logic [ADDR_W-1:0]      row_addr,
    output logic [ADDR_W-1:0]      col_addr
);

    vdc_state_e      state_q, state_d;
    vdc_row_sample_t row_q, row_d;

    logic [VDC_NUM_OPS-1:0] op_d;
    logic                   err_d;
    logic [ADDR_W-1:0]      row_addr_d, col_addr_d;

    logic ras_fall, ras_rise, cas_fall;

    assign ras_fall = ras_q & ~ras_n;
    assign ras_rise = ~ras_q & ras_n;
    assign cas_fall = cas_q & ~cas_n;

    // second-stage classification at the column fall
    function automatic logic [VDC_NUM_OPS-1:0] col_decode(
        input vdc_row_sample_t rs,
        input logic            dsf_col
    );
        logic [VDC_NUM_OPS-1:0] v;
        v = '0;
        if (!rs.trg_n) begin
            if (rs.dsf) v[OP_XFER_SPLIT] = 1'b1;
            else        v[OP_XFER_FULL]  = 1'b1;
        end else if (!rs.we_n) begin
            if (dsf_col) v[OP_BLOCK_MASKED] = 1'b1;
            else         v[OP_WRITE_MASKED] = 1'b1;
        end else if (rs.dsf) begin
            if (dsf_col) v[OP_LOAD_COLOR] = 1'b1;
            else         v[OP_LOAD_WMASK] = 1'b1;
        end else begin
            if (dsf_col) v[OP_BLOCK] = 1'b1;
            else         v[OP_WRITE] = 1'b1;
        end
        return v;
    endfunction

    always_comb begin
        state_d    = state_q;
        row_d      = row_q;
        op_d       = '0;
        err_d      = 1'b0;
        row_addr_d = row_addr;
        col_addr_d = col_addr;
        unique case (state_q)
            S_IDLE: begin
                if (ras_fall) begin
                    row_addr_d = addr;
                    if (!cas_n) begin
                        case ({we_n, dsf})
                            2'b00:   err_d = 1'b1;
                            2'b01:   op_d[OP_REF_STOPSET] = 1'b1;
                            2'b10:   op_d[OP_REF_OPTRST]  = 1'b1;
                            default: op_d[OP_REF_NORST]   = 1'b1;
                        endcase
                        state_d = S_WAIT_RAS_HIGH;
                    end else begin
                        row_d.trg_n = trg_n;
                        row_d.we_n  = we_n;
                        row_d.dsf   = dsf;
                        state_d     = S_ROW_OPEN;
                    end
                end
            end
            S_ROW_OPEN: begin
                if (cas_fall) begin
                    col_addr_d = addr;
                    op_d       = col_decode(row_q, dsf);
                    state_d    = ras_rise ? S_IDLE : S_WAIT_RAS_HIGH;
                end else if (ras_rise) begin
                    state_d = S_IDLE;
                end
            end
            S_WAIT_RAS_HIGH: begin
                if (ras_rise) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_strobe   <= '0;
            op_reserved <= 1'b0;
            row_addr    <= '0;
            col_addr    <= '0;
        end else begin
            op_strobe   <= op_d;
            op_reserved <= err_d;
            row_addr    <= row_addr_d;
            col_addr    <= col_addr_d;
        end
    end

    // R12
    op_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_strobe));

    // R3
    reserved_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_reserved |-> (op_strobe == '0));

    // R4
    xfer_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_strobe[OP_XFER_FULL] || op_strobe[OP_XFER_SPLIT]) |-> $past(cas_fall));

endmodule

// File: rtl/vdc_mode_flags.sv
module vdc_mode_flags #(
    parameter int STOP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_wmask,
    input  logic              do_stopset,
    input  logic              do_optrst,
    input  logic              do_norst,
    input  logic              do_reserved,
    input  logic [STOP_W-1:0] code_src,
    output logic              pwpb_mode,
    output logic              stop_mode,
    output logic [STOP_W-1:0] stop_code
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwpb_mode <= 1'b0;
            stop_mode <= 1'b0;
            stop_code <= '0;
        end else if (do_optrst) begin
            pwpb_mode <= 1'b0;
            stop_mode <= 1'b0;
        end else begin
            if (do_wmask) pwpb_mode <= 1'b1;
            if (do_stopset) begin
                stop_mode <= 1'b1;
                stop_code <= code_src;
            end
        end
    end

    // R8
    pwpb_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwpb_mode) |-> $past(do_wmask));

    // R8
    pwpb_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwpb_mode) |-> $past(do_optrst));

    // R9
    stop_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_mode) |-> $past(do_stopset));

    // R10
    norst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_norst |=> ($stable(pwpb_mode) && $stable(stop_mode)));

    // R3
    reserved_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_reserved |=> ($stable(pwpb_mode) && $stable(stop_mode) && $stable(stop_code)));

endmodule

// File: rtl/vdc_cycle_decoder.sv
module vdc_cycle_decoder
    import vdc_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int BLOCK_COLS = 4,
    parameter int STOP_LSB   = 4,
    parameter int STOP_W     = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ras_n,
    input  logic                                  casl_n,
    input  logic                                  casu_n,
    input  logic                                  trg_n,
    input  logic                                  we_n,
    input  logic                                  dsf,
    input  logic [ADDR_W-1:0]                     addr,
    output logic [VDC_NUM_OPS-1:0]                op_strobe,
    output logic                                  op_reserved,
    output logic [ADDR_W-1:0]                     row_addr,
    output logic [ADDR_W-1:0]                     col_addr,
    output logic [ADDR_W-$clog2(BLOCK_COLS)-1:0]  blk_addr,
    output logic                                  pwpb_mode,
    output logic                                  stop_mode,
    output logic [STOP_W-1:0]                     stop_code
);

    localparam int BLK_SHIFT = $clog2(BLOCK_COLS);

    logic       cas_n;
    logic [1:0] strobe_prev;

    // R1: logical column strobe is low when either byte strobe is low
    assign cas_n = casl_n & casu_n;

    vdc_strobe_sampler #(
        .N          (2),
        .IDLE_LEVEL (1'b1)
    ) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({cas_n, ras_n}),
        .prev  (strobe_prev)
    );

    vdc_cycle_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ras_n       (ras_n),
        .ras_q       (strobe_prev[0]),
        .cas_n       (cas_n),
        .cas_q       (strobe_prev[1]),
        .trg_n       (trg_n),
        .we_n        (we_n),
        .dsf         (dsf),
        .addr        (addr),
        .op_strobe   (op_strobe),
        .op_reserved (op_reserved),
        .row_addr    (row_addr),
        .col_addr    (col_addr)
    );

    vdc_mode_flags #(
        .STOP_W (STOP_W)
    ) u_modes (
        .clk         (clk),
        .rst_n       (rst_n),
        .do_wmask    (op_strobe[OP_LOAD_WMASK]),
        .do_stopset  (op_strobe[OP_REF_STOPSET]),
        .do_optrst   (op_strobe[OP_REF_OPTRST]),
        .do_norst    (op_strobe[OP_REF_NORST]),
        .do_reserved (op_reserved),
        .code_src    (row_addr[STOP_LSB +: STOP_W]),
        .pwpb_mode   (pwpb_mode),
        .stop_mode   (stop_mode),
        .stop_code   (stop_code)
    );

    assign blk_addr = col_addr[ADDR_W-1:BLK_SHIFT];

endmodule

// File: tb/test_vdc_cycle_decoder.sv
module test_vdc_cycle_decoder;

    localparam int B_STOPSET = 0, B_OPTRST = 1, B_NORST = 2, B_FULL = 3, B_SPLIT = 4;
    localparam int B_WR = 5, B_WRM = 6, B_BW = 7, B_BWM = 8, B_LMR = 9, B_LCR = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ras_n = 1'b1, casl_n = 1'b1, casu_n = 1'b1;
    logic       trg_n = 1'b1, we_n = 1'b1, dsf = 1'b0;
    logic [8:0] addr = '0;
    logic [10:0] op_strobe;
    logic       op_reserved, pwpb_mode, stop_mode;
    logic [8:0] row_addr, col_addr;
    logic [6:0] blk_addr;
    logic [3:0] stop_code;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [10:0] op;
        logic        err;
        logic [8:0]  row;
        logic [8:0]  col;
        logic        use_col;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    vdc_cycle_decoder i_vdc_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .casu_n(casu_n),
        .trg_n(trg_n), .we_n(we_n), .dsf(dsf), .addr(addr),
        .op_strobe(op_strobe), .op_reserved(op_reserved), .row_addr(row_addr),
        .col_addr(col_addr), .blk_addr(blk_addr), .pwpb_mode(pwpb_mode),
        .stop_mode(stop_mode), .stop_code(stop_code)
    );

    function automatic logic [10:0] bit_of(int b);
        return 11'(1) << b;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per observed pulse
    always @(negedge clk) begin
        if (rst_n && (op_strobe != '0 || op_reserved)) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected pulse actual op=%0h err=%0b expected none",
                         op_strobe, op_reserved);
            end else begin
                exp_item_t e;
                logic bad;
                e = sb_q.pop_front();
                bad = (op_strobe !== e.op) || (op_reserved !== e.err) || (row_addr !== e.row);
                if (e.use_col && ((col_addr !== e.col) || (blk_addr !== e.col[8:2]))) bad = 1'b1;
                if (bad) begin
                    errors++;
                    $display("FAIL %s actual op=%0h err=%0b row=%0h col=%0h blk=%0h expected op=%0h err=%0b row=%0h col=%0h",
                             e.tag, op_strobe, op_reserved, row_addr, col_addr, blk_addr,
                             e.op, e.err, e.row, e.col);
                end
            end
        end
    end

    task automatic push(logic [10:0] op, logic err, logic [8:0] row, logic [8:0] col,
                        logic use_col, string tag);
        exp_item_t e;
        e.op = op; e.err = err; e.row = row; e.col = col; e.use_col = use_col; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic release_all();
        ras_n = 1'b1; casl_n = 1'b1; casu_n = 1'b1; we_n = 1'b1; trg_n = 1'b1; dsf = 1'b0;
    endtask

    task automatic cbr_cycle(logic we, logic d, logic [8:0] a, logic upper,
                             logic [10:0] op, logic err, string tag);
        push(op, err, a, '0, 1'b0, tag);
        @(negedge clk);
        we_n = we; dsf = d; addr = a;
        if (upper) casu_n = 1'b0; else casl_n = 1'b0;
        @(negedge clk);
        ras_n = 1'b0;
        repeat (3) @(negedge clk);
        release_all();
        repeat (3) @(negedge clk);
    endtask

    task automatic col_cycle(logic trg, logic we, logic d_row, logic d_col,
                             logic [8:0] row, logic [8:0] col, logic upper,
                             logic [10:0] op, string tag);
        push(op, 1'b0, row, col, 1'b1, tag);
        @(negedge clk);
        trg_n = trg; we_n = we; dsf = d_row; addr = row;
        @(negedge clk);
        ras_n = 1'b0;
        repeat (2) @(negedge clk);
        dsf = d_col; addr = col;
        if (upper) casu_n = 1'b0; else casl_n = 1'b0;
        repeat (3) @(negedge clk);
        release_all();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset op_strobe", 32'(op_strobe), 0);
        chk("R12 reset flags", {29'd0, op_reserved, pwpb_mode, stop_mode}, 0);
        chk("R12 reset stop_code", 32'(stop_code), 0);

        // R2 no-reset refresh, R10 flags untouched
        cbr_cycle(1'b1, 1'b1, 9'h055, 1'b0, bit_of(B_NORST), 1'b0, "R2 norst refresh");
        chk("R10 norst flags", {30'd0, pwpb_mode, stop_mode}, 0);

        // R6 register loads, R8 set
        col_cycle(1'b1, 1'b1, 1'b1, 1'b0, 9'h012, 9'h000, 1'b0, bit_of(B_LMR), "R6 wmask load");
        chk("R8 pwpb set by wmask load", 32'(pwpb_mode), 1);
        col_cycle(1'b1, 1'b1, 1'b1, 1'b1, 9'h013, 9'h001, 1'b1, bit_of(B_LCR), "R6 colour load");
        chk("R8 pwpb kept by colour load", 32'(pwpb_mode), 1);

        // R9 stop-point set via upper strobe only (R1), junk in bits 8 and 3:0
        cbr_cycle(1'b0, 1'b1, 9'b1_1010_0111, 1'b1, bit_of(B_STOPSET), 1'b0, "R1 R9 stopset upper cas");
        chk("R9 stop_mode", 32'(stop_mode), 1);
        chk("R9 stop_code", 32'(stop_code), 32'hA);

        // R10 no-reset refresh keeps both flags
        cbr_cycle(1'b1, 1'b1, 9'h1FF, 1'b1, bit_of(B_NORST), 1'b0, "R1 R10 norst upper cas");
        chk("R10 norst keeps flags", {30'd0, pwpb_mode, stop_mode}, 3);

        // R3 reserved
        cbr_cycle(1'b0, 1'b0, 9'h0F0, 1'b0, '0, 1'b1, "R3 reserved");
        chk("R3 reserved keeps flags", {30'd0, pwpb_mode, stop_mode}, 3);
        chk("R3 reserved keeps code", 32'(stop_code), 32'hA);

        // R4 transfers
        col_cycle(1'b0, 1'b1, 1'b0, 1'b1, 9'h101, 9'h1A5, 1'b0, bit_of(B_FULL), "R4 full transfer");
        col_cycle(1'b0, 1'b1, 1'b1, 1'b0, 9'h102, 9'h033, 1'b1, bit_of(B_SPLIT), "R4 split transfer");

        // R7 plain write / block write
        col_cycle(1'b1, 1'b1, 1'b0, 1'b0, 9'h0AA, 9'h0F0, 1'b0, bit_of(B_WR), "R7 write");
        col_cycle(1'b1, 1'b1, 1'b0, 1'b1, 9'h0AB, 9'h1FD, 1'b0, bit_of(B_BW), "R7 block write");

        // R5 masked family
        col_cycle(1'b1, 1'b0, 1'b0, 1'b0, 9'h0C0, 9'h044, 1'b1, bit_of(B_WRM), "R5 masked write");
        col_cycle(1'b1, 1'b0, 1'b1, 1'b1, 9'h0C1, 9'h08B, 1'b0, bit_of(B_BWM), "R5 masked block write");
        chk("R8 pwpb kept by writes", 32'(pwpb_mode), 1);

        // R10 option reset clears both
        cbr_cycle(1'b1, 1'b0, 9'h000, 1'b0, bit_of(B_OPTRST), 1'b0, "R10 option reset");
        chk("R10 R8 optrst clears flags", {30'd0, pwpb_mode, stop_mode}, 0);

        // R11 column fall coincident with row rise
        push(bit_of(B_WR), 1'b0, 9'h111, 9'h0E6, 1'b1, "R11 coincident cas fall ras rise");
        @(negedge clk);
        addr = 9'h111;
        @(negedge clk);
        ras_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = 9'h0E6; casl_n = 1'b0; ras_n = 1'b1;
        @(negedge clk);
        casl_n = 1'b1;
        @(negedge clk);
        col_cycle(1'b1, 1'b1, 1'b0, 1'b1, 9'h112, 9'h0F4, 1'b0, bit_of(B_BW), "R11 access after coincidence");

        // R11 row cycle with no column fall
        @(negedge clk);
        addr = 9'h077;
        @(negedge clk);
        ras_n = 1'b0;
        repeat (4) @(negedge clk);
        ras_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 no pulse without cas fall", 32'(op_strobe), 0);

        repeat (4) @(negedge clk);
        chk("R12 all expected pulses seen", 32'(sb_q.size()), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule